// File: doc/BRIEF.md
# Zero-Latency Fall-Through FIFO

A small register-based first-in first-out buffer placed between a sender and a receiver that share a clock. The sender raises `shiftIn` to offer `dataIn`. The receiver raises `shiftOut` to take the word shown on `dataOut`. A receiver with a stop-style handshake connects its stop signal inverted to `shiftOut`. The storage depth is a parameter, with 3 or 7 words as typical values.

When the buffer holds nothing and the zero-latency option is on, the incoming word is routed straight to `dataOut` in the same cycle. If the receiver takes it in that cycle, the word is never stored. When the buffer is full, `fifoFull` is withdrawn in any cycle where the receiver is reading. This lets the sender keep streaming without a stop bubble, so a full buffer takes one word in while it hands one word out. With the option off, the output always comes from storage.

Occupancy is tracked by a counter that the full and empty flags are derived from. A read pointer and a write pointer wrap over the storage words.

Top module: `zlf_fifo`

## Requirements
- R1: While `rstN` is low, and after it is released, the buffer is empty: with `shiftIn` low, `fifoEmpty` is 1 and `fifoFull` is 0.
- R2: With ZERO_LAT=1 and no words stored, raising `shiftIn` drives `dataOut` equal to `dataIn` and `fifoEmpty` to 0 in the same cycle.
- R3: Accepted words leave on `dataOut` in the order they were accepted, with none lost or repeated.
- R4: Occupancy rises by one on an accepted write without a read and falls by one on a read without a write; otherwise it holds. `fifoFull` means DEPTH words are stored and `fifoEmpty` means none are stored, subject to R2, R5 and R8.
- R5: With ZERO_LAT=1 and DEPTH words stored, `fifoFull` is 0 in any cycle with `shiftOut` high. A write in that cycle is accepted while the oldest word leaves, and occupancy stays at DEPTH.
- R6: A write while DEPTH words are stored and no read is made (in ZERO_LAT=0 mode, with or without a read) is ignored. The stored words and their order are unchanged.
- R7: A read while nothing is stored and nothing is passing through is ignored. The buffer stays empty.
- R8: With ZERO_LAT=0, `fifoEmpty` and `fifoFull` follow the stored count only. A word written into an empty buffer appears on `dataOut` from the next cycle.
- R9: With ZERO_LAT=1 and no words stored, `shiftIn` and `shiftOut` high together deliver the word without storing it. The buffer is still empty in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftIn | input | 1 | Sender offers `dataIn` this cycle |
| dataIn | input | DATA_W | Word from the sender |
| fifoFull | output | 1 | Sender must hold its word |
| shiftOut | input | 1 | Receiver takes `dataOut` this cycle (inverted stop) |
| dataOut | output | DATA_W | Oldest word, or `dataIn` when bypassing |
| fifoEmpty | output | 1 | No word available on `dataOut` |

## Verification
The bench runs a bypass instance and a registered instance side by side through biased pseudo-random sweeps. The sweeps fill the buffer, drain it and keep it balanced, so every pairing of write and read occurs at every occupancy from zero to DEPTH. These corner cases are targeted:
- Same-cycle pass-through at zero occupancy. A faulty design would store the word and deliver it twice.
- Reads at zero occupancy. A faulty design would let the count wrap and present stale words.
- Writes into a full buffer with and without a read. A faulty design would either raise a false stop or overwrite the oldest word.
- The registered variant. A faulty design would leak `dataIn` to the output or clear `fifoEmpty` one cycle early.

// File: rtl/zlf_pkg.sv
package zlf_pkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic wrEn;  // store dataIn at the write pointer
    logic rdEn;  // retire the word at the read pointer
  } zlfStrobe_t;
endpackage

// File: rtl/zlf_ctrl.sv
module zlf_ctrl
  import zlf_pkg::*;
#(
  parameter int DEPTH    = 3,
  parameter bit ZERO_LAT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftIn,
  input  logic       shiftOut,
  output zlfStrobe_t strobe,
  output logic       bufEmpty,
  output logic       fifoEmpty,
  output logic       fifoFull
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             fullReg;
  logic             passThru;
  logic             canWrite;

  assign fullReg  = (count == CNT_MAX);
  assign bufEmpty = (count == '0);

  generate
    if (ZERO_LAT) begin : g_bypass
      assign passThru  = bufEmpty & shiftIn & shiftOut;
      assign canWrite  = ~fullReg | shiftOut;
      assign fifoFull  = fullReg & ~shiftOut;
      assign fifoEmpty = bufEmpty & ~shiftIn;
    end else begin : g_registered
      assign passThru  = 1'b0;
      assign canWrite  = ~fullReg;
      assign fifoFull  = fullReg;
      assign fifoEmpty = bufEmpty;
    end
  endgenerate

  assign strobe.rdEn = shiftOut & ~bufEmpty;
  assign strobe.wrEn = shiftIn & ~passThru & canWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.wrEn && !strobe.rdEn) begin
      count <= count + 1'b1;
    end else if (!strobe.wrEn && strobe.rdEn) begin
      count <= count - 1'b1;
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);

  assert_full_write_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fullReg && shiftIn && !shiftOut) |=> (count == CNT_MAX));

  assert_empty_read_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && shiftOut && !shiftIn) |=> bufEmpty);

  generate
    if (ZERO_LAT) begin : g_bypass_checks
      assert_full_swap_R5: assert property (@(posedge clk) disable iff (!rstN)
        (fullReg && shiftIn && shiftOut) |=> fullReg);
      assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rstN)
        (bufEmpty && shiftIn && shiftOut) |=> bufEmpty);
    end
  endgenerate
endmodule

// File: rtl/zlf_datapath.sv
module zlf_datapath
  import zlf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 3,
  parameter bit ZERO_LAT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  zlfStrobe_t        strobe,
  input  logic              bufEmpty,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] headWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      mem[wrPtr] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.rdEn) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  assign headWord = mem[rdPtr];

  generate
    if (ZERO_LAT) begin : g_bypass_mux
      assign dataOut = bufEmpty ? dataIn : headWord;
    end else begin : g_registered_out
      assign dataOut = headWord;
    end
  endgenerate

  assert_wrptr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(wrPtr));

  assert_rdptr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdPtr));

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= PTR_LAST) && (rdPtr <= PTR_LAST));
endmodule

// File: rtl/zlf_fifo.sv
module zlf_fifo
  import zlf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 3,
  parameter bit ZERO_LAT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              fifoFull,
  input  logic              shiftOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              fifoEmpty
);
  zlfStrobe_t strobe;
  logic       bufEmpty;

  zlf_ctrl #(.DEPTH(DEPTH), .ZERO_LAT(ZERO_LAT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .strobe   (strobe),
    .bufEmpty (bufEmpty),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull)
  );

  zlf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ZERO_LAT(ZERO_LAT)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bufEmpty(bufEmpty),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/zlf_fifo_bench.sv
`timescale 1ns/1ps
module zlf_fifo_bench;
  localparam int D = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic si = 1'b0, so = 1'b0;
  logic [W-1:0] din = '0;
  logic fullZ, emptyZ, fullR, emptyR;
  logic [W-1:0] doutZ, doutR;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  zlf_fifo #(.DATA_W(W), .DEPTH(D), .ZERO_LAT(1'b1)) u_zlf_fifo (
    .clk(clk), .rstN(rstN), .shiftIn(si), .dataIn(din), .fifoFull(fullZ),
    .shiftOut(so), .dataOut(doutZ), .fifoEmpty(emptyZ));

  zlf_fifo #(.DATA_W(W), .DEPTH(D), .ZERO_LAT(1'b0)) u_zlf_fifo_reg (
    .clk(clk), .rstN(rstN), .shiftIn(si), .dataIn(din), .fifoFull(fullR),
    .shiftOut(so), .dataOut(doutR), .fifoEmpty(emptyR));

  // reference models: occupancy and stored words, oldest at index 0
  int mz = 0, mr = 0;
  logic [W-1:0] qz [D];
  logic [W-1:0] qr [D];

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(inout logic [W-1:0] q [D], inout int n, input logic [W-1:0] v);
    q[n] = v;
    n++;
  endtask

  task automatic pop(inout logic [W-1:0] q [D], inout int n);
    for (int k = 0; k < D - 1; k++) q[k] = q[k+1];
    n--;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    string tagE, tagF, tagD;
    logic expEmpty, expFull;
    logic [W-1:0] expData;
    bit rdZ, wrZ, passZ, rdR, wrR;
    lfsr = 16'hACE1;

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1", "emptyZ in reset", {31'b0, emptyZ}, 32'd1);
    check("R1", "fullZ in reset", {31'b0, fullZ}, 32'd0);
    check("R1", "emptyR in reset", {31'b0, emptyR}, 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "emptyZ after reset", {31'b0, emptyZ}, 32'd1);
    check("R1", "fullR after reset", {31'b0, fullR}, 32'd0);

    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case ((i / 50) % 3)
        0: begin si = lfsr[0] | lfsr[1]; so = lfsr[2] & lfsr[3]; end
        1: begin si = lfsr[0] & lfsr[1]; so = lfsr[2] | lfsr[3]; end
        default: begin si = lfsr[4]; so = lfsr[5]; end
      endcase
      din = W'(i * 7 + 3);
      #1;

      // bypass instance: R2, R3, R4, R5, R6, R7, R9
      expEmpty = (mz == 0) && !si;
      expFull  = (mz == D) && !so;
      expData  = (mz == 0) ? din : qz[0];
      tagE = (mz == 0 && si && so) ? "R9" : (mz == 0 && so) ? "R7" : (mz == 0) ? "R2" : "R4";
      tagF = (mz == D) ? (so ? "R5" : "R6") : "R4";
      tagD = (mz == 0) ? "R2" : "R3";
      check(tagE, "fifoEmpty bypass", {31'b0, emptyZ}, {31'b0, expEmpty});
      check(tagF, "fifoFull bypass", {31'b0, fullZ}, {31'b0, expFull});
      if (!expEmpty) check(tagD, "dataOut bypass", {24'b0, doutZ}, {24'b0, expData});

      // registered instance: R8 (also R3, R6, R7 ordering)
      check("R8", "fifoEmpty registered", {31'b0, emptyR}, {31'b0, mr == 0});
      check("R8", "fifoFull registered", {31'b0, fullR}, {31'b0, mr == D});
      if (mr > 0) check("R8", "dataOut registered", {24'b0, doutR}, {24'b0, qr[0]});

      @(posedge clk);
      passZ = (mz == 0) && si && so;
      rdZ = so && (mz > 0);
      wrZ = si && !passZ && ((mz < D) || so);
      if (rdZ) pop(qz, mz);
      if (wrZ) push(qz, mz, din);
      rdR = so && (mr > 0);
      wrR = si && (mr < D);
      if (rdR) pop(qr, mr);
      if (wrR) push(qr, mr, din);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule